// File: doc/BRIEF.md
# Multi-Channel Bus-Bridging DMA Engine

This block is an eight-channel copy engine that sits between a wide memory bus (the A side, 24-bit addresses) and a narrow peripheral bus (the B side, one 256-register page) that share a single data bus. The engine never holds the data. For each byte it drives a read strobe on one bus and a write strobe on the other in the same cycle, and the source device drives the shared data lines straight into the destination.

Software loads each channel's settings through an 8-bit register port. The settings are the direction, the A-pointer adjust mode, the B-offset pattern, the B register index, the A address and the byte count. Software then writes a start mask. Every selected channel runs to completion in ascending channel order, one byte per clock, and a stall output holds the processor until the last channel finishes. A pause input lets a higher-priority agent take both buses for as many cycles as it needs. The interrupted transfer then continues exactly where it stopped.

Top module: `bridge_dma`

## Requirements
- R1: When `start_we` is high with a non-zero `start_mask` and `stall` is low, the selected channels run from the lowest index to the highest. `stall` reads 1 from the cycle after the write until the cycle after the last byte's strobes. `done` is then high for exactly one cycle, in the first cycle that `stall` reads 0.
- R2: Parameter byte bit 7 is the direction. With 0, each byte asserts `a_rd` and `b_wr` together. With 1, each byte asserts `b_rd` and `a_wr` together. Read and write strobes of the same bus are never high at once.
- R3: Parameter bits [4:3] set the adjust mode. After each byte, 0 adds 1 to the low 16 address bits, 2 subtracts 1, and 1 or 3 leaves them unchanged, so every byte of a fill uses one address.
- R4: Address bits [23:16] (the bank) never change during a transfer. The low 16 bits wrap from 0xFFFF to 0x0000, and from 0x0000 to 0xFFFF.
- R5: The 16-bit count gives the number of bytes, and 0 means 65536. A channel can stop part-way through its pattern. After the channel finishes, its count reads 0 and its address reads the advanced value.
- R6: Parameter bits [2:0] select the repeating B offset sequence, which restarts for each channel. Code 0 gives +0. Code 1 and code 5 give +0 +1. Codes 2 and 6 give +0 +0. Codes 3 and 7 give +0 +0 +1 +1. Code 4 gives +0 +1 +2 +3.
- R7: `b_addr` is 0x21 in the high byte and (index + offset) modulo 256 in the low byte.
- R8: A cycle in which `pause` is high at the clock edge moves no byte, so no strobe is seen in the following cycle. The byte sequence is identical with or without pauses.
- R9: After reset, every parameter, index, address and count byte of every channel reads 0xFF, and `stall` and `done` are 0.
- R10: Register address = channel*16 + offset. The offsets are: 0 parameter, 1 B index, 2/3/4 address low/high/bank, 5/6 count low/high. Other offsets read 0. `cfg_rdata` shows the register selected by `cfg_addr` one clock earlier.
- R11: While `stall` is high, writes to the start mask and to channel registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register address (channel, offset) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Registered read data |
| start_we | input | 1 | Start mask write strobe |
| start_mask | input | 8 | One bit per channel to run |
| pause | input | 1 | Suspend byte moves while high |
| stall | output | 1 | Processor hold while transfers pend |
| done | output | 1 | One-cycle completion pulse |
| a_addr | output | 24 | A-bus address |
| a_rd | output | 1 | A-bus read strobe |
| a_wr | output | 1 | A-bus write strobe |
| b_addr | output | 16 | B-bus address |
| b_rd | output | 1 | B-bus read strobe |
| b_wr | output | 1 | B-bus write strobe |

## Verification
The hardest case to reach from the ports is a transfer that is suspended in the middle of a multi-byte pattern, or right on the last byte of one channel before the next channel begins. The resumed stream must not skip, repeat or restart a pattern step. The stimulus raises `pause` on random cycles while multi-channel runs of random length and pattern are in progress. The captured strobe stream is then compared against a model stream computed without pauses. Directed runs cover bank wrap, 8-bit index wrap, fixed-address fills, a pattern cut short by the count, the 65536-byte count, and start and register writes issued while the processor is stalled.

// File: rtl/bridge_dma_pkg.sv
package bridge_dma_pkg;
  localparam int ALW   = 16;  // moving part of the A address
  localparam int BKW   = 8;   // fixed bank part of the A address
  localparam int CNTW  = 16;  // byte counter width
  localparam int BYTEW = 8;

  typedef enum logic [1:0] {
    ADJ_INC  = 2'd0,
    ADJ_FIX  = 2'd1,
    ADJ_DEC  = 2'd2,
    ADJ_FIX2 = 2'd3
  } adj_e;

  // Offset added to the B index at pattern step 'step'.
  function automatic logic [1:0] pat_offset(input logic [2:0] pat, input logic [1:0] step);
    logic [1:0] r;
    case (pat)
      3'd1, 3'd5: r = {1'b0, step[0]};
      3'd3, 3'd7: r = {1'b0, step[1]};
      3'd4:       r = step;
      default:    r = 2'd0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bridge_dma_regs.sv
module bridge_dma_regs import bridge_dma_pkg::*; #(
  parameter int CH = 8,
  localparam int CHW = $clog2(CH),
  localparam int RAW = CHW + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic [RAW-1:0]    cpu_addr,
  input  logic [BYTEW-1:0]  cpu_wdata,
  output logic [BYTEW-1:0]  cpu_rdata,
  input  logic              lock,
  input  logic [CHW-1:0]    sel_ch,
  output logic              sel_dir,
  output logic [1:0]        sel_adj,
  output logic [2:0]        sel_pat,
  output logic [BYTEW-1:0]  sel_bix,
  output logic [ALW-1:0]    sel_lo,
  output logic [BKW-1:0]    sel_bank,
  output logic [CNTW-1:0]   sel_cnt,
  input  logic              upd,
  input  logic [ALW-1:0]    upd_lo,
  input  logic [CNTW-1:0]   upd_cnt
);
  logic [CH-1:0][BYTEW-1:0] prm_v, bix_v;
  logic [CH-1:0][ALW-1:0]   lo_v;
  logic [CH-1:0][BKW-1:0]   bk_v;
  logic [CH-1:0][CNTW-1:0]  cnt_v;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [BYTEW-1:0] prm_q, bix_q;
    logic [ALW-1:0]   lo_q;
    logic [BKW-1:0]   bk_q;
    logic [CNTW-1:0]  cnt_q;
    logic             hit;
    assign hit = cpu_we && !lock && (cpu_addr[RAW-1:4] == CHW'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        prm_q <= '1;
        bix_q <= '1;
        lo_q  <= '1;
        bk_q  <= '1;
        cnt_q <= '1;
      end else if (upd && sel_ch == CHW'(c)) begin
        lo_q  <= upd_lo;
        cnt_q <= upd_cnt;
      end else if (hit) begin
        case (cpu_addr[3:0])
          4'd0: prm_q       <= cpu_wdata;
          4'd1: bix_q       <= cpu_wdata;
          4'd2: lo_q[7:0]   <= cpu_wdata;
          4'd3: lo_q[15:8]  <= cpu_wdata;
          4'd4: bk_q        <= cpu_wdata;
          4'd5: cnt_q[7:0]  <= cpu_wdata;
          4'd6: cnt_q[15:8] <= cpu_wdata;
          default: ;
        endcase
      end
    end

    assign prm_v[c] = prm_q;
    assign bix_v[c] = bix_q;
    assign lo_v[c]  = lo_q;
    assign bk_v[c]  = bk_q;
    assign cnt_v[c] = cnt_q;
  end

  logic [CHW-1:0] rch;
  assign rch = cpu_addr[RAW-1:4];

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
    end else begin
      case (cpu_addr[3:0])
        4'd0:    cpu_rdata <= prm_v[rch];
        4'd1:    cpu_rdata <= bix_v[rch];
        4'd2:    cpu_rdata <= lo_v[rch][7:0];
        4'd3:    cpu_rdata <= lo_v[rch][15:8];
        4'd4:    cpu_rdata <= bk_v[rch];
        4'd5:    cpu_rdata <= cnt_v[rch][7:0];
        4'd6:    cpu_rdata <= cnt_v[rch][15:8];
        default: cpu_rdata <= '0;
      endcase
    end
  end

  logic [BYTEW-1:0] sel_prm;
  assign sel_prm  = prm_v[sel_ch];
  assign sel_dir  = sel_prm[7];
  assign sel_adj  = sel_prm[4:3];
  assign sel_pat  = sel_prm[2:0];
  assign sel_bix  = bix_v[sel_ch];
  assign sel_lo   = lo_v[sel_ch];
  assign sel_bank = bk_v[sel_ch];
  assign sel_cnt  = cnt_v[sel_ch];

  // R11: a locked register port leaves the addressed parameter byte alone
  assert_locked_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (lock && !upd) |=> $stable(prm_v));
endmodule

// File: rtl/bridge_dma_seq.sv
module bridge_dma_seq import bridge_dma_pkg::*; #(
  parameter int CH = 8,
  parameter logic [BYTEW-1:0] BPAGE = 8'h21,
  localparam int CHW = $clog2(CH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_we,
  input  logic [CH-1:0]        start_mask,
  input  logic                 pause,
  input  logic                 sel_dir,
  input  logic [1:0]           sel_adj,
  input  logic [2:0]           sel_pat,
  input  logic [BYTEW-1:0]     sel_bix,
  input  logic [ALW-1:0]       sel_lo,
  input  logic [BKW-1:0]       sel_bank,
  input  logic [CNTW-1:0]      sel_cnt,
  output logic [CHW-1:0]       sel_ch,
  output logic                 upd,
  output logic [ALW-1:0]       upd_lo,
  output logic [CNTW-1:0]      upd_cnt,
  output logic [BKW+ALW-1:0]   a_addr,
  output logic                 a_rd,
  output logic                 a_wr,
  output logic [2*BYTEW-1:0]   b_addr,
  output logic                 b_rd,
  output logic                 b_wr,
  output logic                 stall,
  output logic                 done
);
  logic [CH-1:0]  pend_q, pend_d;
  logic [CHW-1:0] cur, xch_q;
  logic [1:0]     step_q;
  logic           go, last;

  // lowest pending channel wins
  always_comb begin
    cur = '0;
    for (int i = CH - 1; i >= 0; i--) begin
      if (pend_q[i]) cur = CHW'(i);
    end
  end

  assign go      = (|pend_q) && !pause;
  assign last    = (sel_cnt == CNTW'(1));
  assign sel_ch  = cur;
  assign upd     = go;
  assign upd_cnt = sel_cnt - CNTW'(1);

  always_comb begin
    case (adj_e'(sel_adj))
      ADJ_INC: upd_lo = sel_lo + ALW'(1);
      ADJ_DEC: upd_lo = sel_lo - ALW'(1);
      default: upd_lo = sel_lo;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (go && last) pend_d[cur] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      stall  <= 1'b0;
      done   <= 1'b0;
      step_q <= '0;
      a_rd   <= 1'b0;
      a_wr   <= 1'b0;
      b_rd   <= 1'b0;
      b_wr   <= 1'b0;
      a_addr <= '0;
      b_addr <= '0;
      xch_q  <= '0;
    end else begin
      done <= stall && !(|pend_q);
      if (start_we && !stall) begin
        pend_q <= start_mask;
        stall  <= |start_mask;
      end else begin
        pend_q <= pend_d;
        stall  <= |pend_q;
      end
      if (go) begin
        step_q <= last ? 2'd0 : step_q + 2'd1;
        a_addr <= {sel_bank, sel_lo};
        b_addr <= {BPAGE, sel_bix + BYTEW'(pat_offset(sel_pat, step_q))};
        xch_q  <= cur;
      end
      a_rd <= go && !sel_dir;
      b_wr <= go && !sel_dir;
      b_rd <= go && sel_dir;
      a_wr <= go && sel_dir;
    end
  end

  // R2: each byte pairs a read on one bus with a write on the other
  assert_paired_strobes_R2: assert property (@(posedge clk) disable iff (rst)
    (a_rd == b_wr) && (a_wr == b_rd) && !(a_rd && a_wr));

  // R8: a paused cycle moves no byte
  assert_pause_idle_R8: assert property (@(posedge clk) disable iff (rst)
    pause |=> !(a_rd || a_wr));

  // R1: bus activity only while the processor is held
  assert_strobe_in_stall_R1: assert property (@(posedge clk) disable iff (rst)
    (a_rd || a_wr) |-> stall);

  // R1: completion pulse follows the end of the stall
  assert_done_after_stall_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> (!stall && $past(stall)));

  // R4: the bank byte holds across consecutive bytes of one channel
  assert_bank_fixed_R4: assert property (@(posedge clk) disable iff (rst)
    ((a_rd || a_wr) && $past(a_rd || a_wr) && xch_q == $past(xch_q))
      |-> a_addr[BKW+ALW-1:ALW] == $past(a_addr[BKW+ALW-1:ALW]));
endmodule

// File: rtl/bridge_dma.sv
module bridge_dma import bridge_dma_pkg::*; #(
  parameter int CH = 8,
  parameter logic [BYTEW-1:0] BPAGE = 8'h21,
  localparam int CHW = $clog2(CH)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [CHW+3:0]       cfg_addr,
  input  logic [BYTEW-1:0]     cfg_wdata,
  output logic [BYTEW-1:0]     cfg_rdata,
  input  logic                 start_we,
  input  logic [CH-1:0]        start_mask,
  input  logic                 pause,
  output logic                 stall,
  output logic                 done,
  output logic [BKW+ALW-1:0]   a_addr,
  output logic                 a_rd,
  output logic                 a_wr,
  output logic [2*BYTEW-1:0]   b_addr,
  output logic                 b_rd,
  output logic                 b_wr
);
  logic [CHW-1:0]   sel_ch;
  logic             sel_dir, upd;
  logic [1:0]       sel_adj;
  logic [2:0]       sel_pat;
  logic [BYTEW-1:0] sel_bix;
  logic [ALW-1:0]   sel_lo, upd_lo;
  logic [BKW-1:0]   sel_bank;
  logic [CNTW-1:0]  sel_cnt, upd_cnt;

  bridge_dma_regs #(.CH(CH)) u_regs (
    .clk(clk), .rst(rst),
    .cpu_we(cfg_we), .cpu_addr(cfg_addr), .cpu_wdata(cfg_wdata), .cpu_rdata(cfg_rdata),
    .lock(stall), .sel_ch(sel_ch),
    .sel_dir(sel_dir), .sel_adj(sel_adj), .sel_pat(sel_pat), .sel_bix(sel_bix),
    .sel_lo(sel_lo), .sel_bank(sel_bank), .sel_cnt(sel_cnt),
    .upd(upd), .upd_lo(upd_lo), .upd_cnt(upd_cnt)
  );

  bridge_dma_seq #(.CH(CH), .BPAGE(BPAGE)) u_seq (
    .clk(clk), .rst(rst),
    .start_we(start_we), .start_mask(start_mask), .pause(pause),
    .sel_dir(sel_dir), .sel_adj(sel_adj), .sel_pat(sel_pat), .sel_bix(sel_bix),
    .sel_lo(sel_lo), .sel_bank(sel_bank), .sel_cnt(sel_cnt),
    .sel_ch(sel_ch), .upd(upd), .upd_lo(upd_lo), .upd_cnt(upd_cnt),
    .a_addr(a_addr), .a_rd(a_rd), .a_wr(a_wr),
    .b_addr(b_addr), .b_rd(b_rd), .b_wr(b_wr),
    .stall(stall), .done(done)
  );
endmodule

// File: tb/tb_bridge_dma.sv
module tb_bridge_dma;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, cfg_we, start_we, pause;
  logic [6:0]  cfg_addr;
  logic [7:0]  cfg_wdata, cfg_rdata, start_mask;
  logic        stall, done, a_rd, a_wr, b_rd, b_wr;
  logic [23:0] a_addr;
  logic [15:0] b_addr;

  bridge_dma dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .start_we(start_we), .start_mask(start_mask), .pause(pause),
    .stall(stall), .done(done), .a_addr(a_addr), .a_rd(a_rd), .a_wr(a_wr),
    .b_addr(b_addr), .b_rd(b_rd), .b_wr(b_wr)
  );

  int checks = 0, fails = 0;
  logic [7:0]  m_prm [8];
  logic [7:0]  m_bix [8];
  logic [7:0]  m_bk  [8];
  logic [15:0] m_lo  [8];
  logic [15:0] m_cnt [8];

  localparam int CAP = 1024;
  logic [23:0] ea [CAP];
  logic [23:0] oa [CAP];
  logic [15:0] eb [CAP];
  logic [15:0] ob [CAP];
  logic        ew [CAP];
  logic        ow [CAP];
  int en, on, dcnt;
  logic cap_en = 1'b0;

  always @(negedge clk) begin
    if (!cap_en) begin
      on = 0;
      dcnt = 0;
    end else begin
      if (a_rd || a_wr) begin
        if (on < CAP) begin
          oa[on] = a_addr; ob[on] = b_addr; ow[on] = a_wr;
        end
        on++;
      end
      if (done) dcnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int boff(input logic [2:0] p, input int i);
    case (p)
      3'd1, 3'd5: return i % 2;
      3'd3, 3'd7: return (i / 2) % 2;
      3'd4:       return i % 4;
      default:    return 0;
    endcase
  endfunction

  task automatic wreg(input int ch, input int off, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'(ch * 16 + off); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (off)
      0: m_prm[ch] = d;
      1: m_bix[ch] = d;
      2: m_lo[ch][7:0] = d;
      3: m_lo[ch][15:8] = d;
      4: m_bk[ch] = d;
      5: m_cnt[ch][7:0] = d;
      6: m_cnt[ch][15:8] = d;
      default: ;
    endcase
  endtask

  task automatic rreg(input int ch, input int off, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = 7'(ch * 16 + off);
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic setch(input int ch, input logic [7:0] prm, input logic [7:0] bix,
                       input logic [23:0] adr, input logic [15:0] cnt);
    wreg(ch, 0, prm); wreg(ch, 1, bix);
    wreg(ch, 2, adr[7:0]); wreg(ch, 3, adr[15:8]); wreg(ch, 4, adr[23:16]);
    wreg(ch, 5, cnt[7:0]); wreg(ch, 6, cnt[15:8]);
  endtask

  task automatic build(input logic [7:0] mask);
    en = 0;
    for (int c = 0; c < 8; c++) begin
      if (mask[c]) begin
        int n;
        n = (m_cnt[c] == 16'd0) ? 65536 : int'(m_cnt[c]);
        for (int i = 0; i < n; i++) begin
          if (en < CAP) begin
            ea[en] = {m_bk[c], m_lo[c]};
            eb[en] = {8'h21, m_bix[c] + 8'(boff(m_prm[c][2:0], i))};
            ew[en] = m_prm[c][7];
          end
          en++;
          if (m_prm[c][4:3] == 2'd0) m_lo[c] = m_lo[c] + 16'd1;
          else if (m_prm[c][4:3] == 2'd2) m_lo[c] = m_lo[c] - 16'd1;
        end
        m_cnt[c] = 16'd0;
      end
    end
  endtask

  // run the channels in mask; optional random pauses, ignored start and ignored write
  task automatic run(input logic [7:0] mask, input bit rpause,
                     input logic [7:0] extra, input bit poke);
    int lim, bad;
    build(mask);
    cap_en = 1'b1;
    @(negedge clk);
    start_we = 1'b1; start_mask = mask;
    @(negedge clk);
    start_we = 1'b0;
    chk(stall == 1'b1, "R1", "stall after start", stall, 1);
    if (extra != 8'd0) begin
      start_we = 1'b1; start_mask = extra;
      @(negedge clk);
      start_we = 1'b0;
    end
    if (poke) begin
      cfg_we = 1'b1; cfg_addr = 7'(5 * 16 + 1); cfg_wdata = ~m_bix[5];
      @(negedge clk);
      cfg_we = 1'b0;
    end
    while (dcnt == 0) begin
      if (rpause) pause = ($urandom % 3) == 0;
      @(negedge clk);
    end
    pause = 1'b0;
    @(negedge clk);
    chk(dcnt == 1 && !done && !stall, "R1", "single done pulse, stall low", dcnt, 1);
    chk(on == en, "R5", "byte count moved", on, en);
    lim = (en < CAP) ? en : CAP;
    bad = -1;
    for (int i = 0; i < lim; i++) begin
      if (bad < 0 && (oa[i] != ea[i] || ob[i] != eb[i] || ow[i] != ew[i])) bad = i;
    end
    if (bad >= 0)
      chk(1'b0, "R1 R2 R3 R6 R7 R8", "stream a/b/dir",
          {7'd0, ow[bad], ob[bad], oa[bad]}, {7'd0, ew[bad], eb[bad], ea[bad]});
    else
      chk(1'b1, "R1 R2 R3 R6 R7 R8", "stream", 0, 0);
    cap_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_after(input int ch);
    logic [7:0] d0, d1;
    rreg(ch, 5, d0); rreg(ch, 6, d1);
    chk({d1, d0} == 16'd0, "R5", "count reads zero", {d1, d0}, 0);
    rreg(ch, 2, d0); rreg(ch, 3, d1);
    chk({d1, d0} == m_lo[ch], "R5", "advanced address", {d1, d0}, m_lo[ch]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    start_we = 1'b0; start_mask = '0; pause = 1'b0;
    void'($urandom(32'd4242));
    for (int c = 0; c < 8; c++) begin
      m_prm[c] = 8'hFF; m_bix[c] = 8'hFF; m_bk[c] = 8'hFF;
      m_lo[c] = 16'hFFFF; m_cnt[c] = 16'hFFFF;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    chk(!stall && !done, "R9", "stall/done after reset", {stall, done}, 0);
    rreg(0, 0, d); chk(d == 8'hFF, "R9", "ch0 param", d, 8'hFF);
    rreg(3, 4, d); chk(d == 8'hFF, "R9", "ch3 bank", d, 8'hFF);
    rreg(7, 6, d); chk(d == 8'hFF, "R9", "ch7 count high", d, 8'hFF);
    rreg(2, 1, d); chk(d == 8'hFF, "R9", "ch2 index", d, 8'hFF);
    rreg(4, 9, d); chk(d == 8'h00, "R10", "unmapped offset", d, 0);

    // R10 random register readback
    for (int k = 0; k < 6; k++) begin
      int ch, off;
      logic [7:0] v;
      ch = $urandom % 8; off = $urandom % 7; v = 8'($urandom);
      wreg(ch, off, v);
      rreg(ch, off, d);
      chk(d == v, "R10", "register readback", d, v);
    end

    // directed: two channels, pattern 1 increment, pattern 4 decrement with index wrap
    setch(0, 8'b0_00_00_001, 8'h18, 24'h7E1000, 16'd5);
    setch(2, 8'b1_00_10_100, 8'hFE, 24'h001234, 16'd6);
    run(8'h05, 1'b0, 8'h00, 1'b0);
    chk(ob[0] == 16'h2118 && ob[1] == 16'h2119, "R6", "pattern 1 offsets", ob[1], 16'h2119);
    chk(ob[7] == 16'h2100 && ob[8] == 16'h2101, "R7", "index wraps mod 256", ob[7], 16'h2100);
    chk(ow[5] == 1'b1 && ow[4] == 1'b0, "R2", "direction per channel", ow[5], 1);
    check_after(0);
    check_after(2);

    // directed: fixed fill (adjust 1), pattern 2, with pauses
    setch(3, 8'b0_00_01_010, 8'h04, 24'h12ABCD, 16'd3);
    run(8'h08, 1'b1, 8'h00, 1'b0);
    chk(oa[0] == 24'h12ABCD && oa[2] == 24'h12ABCD, "R3", "fixed address fill", oa[2], 24'h12ABCD);
    check_after(3);

    // directed: bank wrap on increment
    setch(1, 8'b0_00_00_011, 8'h40, 24'h45FFFE, 16'd4);
    run(8'h02, 1'b0, 8'h00, 1'b0);
    chk(oa[2] == 24'h450000 && oa[3] == 24'h450001, "R4", "wrap within bank", oa[2], 24'h450000);
    rreg(1, 4, d); chk(d == 8'h45, "R4", "bank unchanged", d, 8'h45);
    check_after(1);

    // R11: start and register writes during stall are ignored
    setch(7, 8'b0_00_00_000, 8'h10, 24'h000100, 16'd9);
    setch(1, 8'b0_00_00_000, 8'h22, 24'h000200, 16'd6);
    run(8'h02, 1'b0, 8'h80, 1'b1);
    rreg(7, 5, d); chk(d == 8'd9, "R11", "ch7 count untouched", d, 9);
    rreg(5, 1, d); chk(d == m_bix[5], "R11", "locked register write", d, m_bix[5]);

    // R5: count zero moves 65536 bytes
    setch(6, 8'b0_00_11_000, 8'h80, 24'h7F0000, 16'd0);
    run(8'h40, 1'b0, 8'h00, 1'b0);
    check_after(6);

    // random multi-channel runs with random pauses (R8)
    for (int r = 0; r < 6; r++) begin
      logic [7:0] mask;
      mask = 8'(($urandom % 255) + 1);
      for (int c = 0; c < 8; c++) begin
        if (mask[c])
          setch(c, 8'($urandom), 8'($urandom), 24'($urandom), 16'(($urandom % 24) + 1));
      end
      run(mask, 1'b1, 8'h00, 1'b0);
      for (int c = 0; c < 8; c++) if (mask[c]) check_after(c);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule